// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block moves bytes over a two-wire synchronous link, one direction at a time. It produces the shift clock on one pin (`sclk_o`). It either drives serial data onto, or samples serial data from, a shared data line (`data_o`, `data_oe`, `data_i`). The register side has three parts: a transmit holding buffer that software writes, a receive buffer that software reads, and a set of control levels and pulses. The control side covers run, receiver enable, loop-back and overrun checking. Bits travel least-significant first. The shift clock idles high, output data changes when the clock falls, and input is sampled when the clock rises. Each clock half lasts `reload + 1` system clocks.

Transmit is double-buffered. When the shifter is free, a written byte moves straight into it and frees the holding buffer for the next byte. Reception takes exactly one byte each time the receiver is enabled, and the enable bit clears itself when that byte lands in the receive buffer. In loop-back mode the outgoing bit stream is fed back inside the block. A byte written with the receiver enabled is then sent and received together.

The controller has three states. It leaves IDLE for LOW when a transfer starts. It goes from LOW to HIGH on a prescaler tick, which is a rising clock edge where a bit is sampled. From HIGH it returns to LOW on a tick while bits remain, which is a falling edge where the next bit goes out. It goes from HIGH back to IDLE on the tick after the last bit, where the done requests pulse.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` and `data_o` are high, `data_oe` is high, all four request outputs are low, and `rxen_o` and `ovf_o` are 0.
- R2: With `cfg_run`=1 and `cfg_loop`=0, a transfer starts no more than 4 clocks after a transmit write while the receiver enable is 0. Starting means `sclk_o` falls. `req_tbuf` pulses for one clock as the byte leaves the holding buffer.
- R3: Each shift-clock half lasts `reload+1` clocks, low half first. `data_o` carries bit 0 first and changes only when `sclk_o` falls.
- R4: After the eighth high half, `sclk_o` and `data_o` are high and `req_txdone` pulses for one clock. A byte written during a transfer is sent next, after one idle clock.
- R5: No transfer starts while `cfg_run`=0. A held byte stays buffered and is sent once `cfg_run` is set.
- R6: In normal mode, with `cfg_run`=1 and the receiver enable set, a receive runs: `data_oe` is 0, and `data_i` is sampled at each rising shift-clock edge into bit positions 0 to 7 in order.
- R7: When the eighth bit is in, `rx_data` takes the byte, `req_rxdone` pulses for one clock and `rxen_o` returns to 0.
- R8: Clearing the receiver enable mid-byte does not stop the byte: it finishes with its `req_rxdone` pulse.
- R9: A transmit write during a receive is discarded. It neither disturbs the receive nor starts a transfer afterwards.
- R10: If a byte completes while the previous one is unread, and `cfg_ovchk`=1, then `ovf_o` sets and `req_err` pulses together with `req_rxdone`. With `cfg_ovchk`=0 neither happens. `rx_rd` marks the buffer read, and `ovf_clr` clears `ovf_o`.
- R11: With `cfg_loop`=1 and the receiver enable set, a transmit write sends the byte and receives it internally, ignoring `data_i`. Both done requests pulse, and `rx_data` equals the sent byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Run enable for the serial engine |
| cfg_loop | input | 1 | Internal loop-back of transmit data |
| cfg_ovchk | input | 1 | Overrun detection enable |
| rxen_set | input | 1 | Pulse: set receiver enable |
| rxen_clr | input | 1 | Pulse: clear receiver enable |
| rxen_o | output | 1 | Current receiver enable bit |
| ovf_clr | input | 1 | Pulse: clear overrun flag |
| ovf_o | output | 1 | Overrun flag |
| reload | input | RW | Shift-clock half-period divider, half = reload+1 clocks |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | DW | Transmit buffer write data |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | DW | Receive buffer contents |
| sclk_o | output | 1 | Shift clock, idles high |
| data_o | output | 1 | Serial data out |
| data_oe | output | 1 | Data line drive enable |
| data_i | input | 1 | Serial data in |
| req_tbuf | output | 1 | Transmit buffer empty request pulse |
| req_txdone | output | 1 | Transmit complete request pulse |
| req_rxdone | output | 1 | Receive complete request pulse |
| req_err | output | 1 | Overrun error request pulse |

## Verification
The hardest case to reach from the ports is an overrun. It needs two complete receives with no read in between and overrun checking on. The stimulus reaches it by re-arming the receiver enable after each self-clear, without pulsing `rx_rd`. It then repeats the same pair with checking off and with a read placed between them. A transmit write dropped during a receive is equally hidden, because the only evidence is a transfer that never happens. The bench therefore leaves run set after the receive and watches the shift clock stay high for many byte times. A behavioural model tracks every pin on every clock, with the data line driven from a pseudo-random sequence.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssp_state_t;

    typedef enum logic [1:0] {
        MD_TX   = 2'd0,
        MD_RX   = 2'd1,
        MD_LOOP = 2'd2
    } ssp_mode_t;

    function automatic logic mode_sends(input ssp_mode_t m);
        return m != MD_RX;
    endfunction

    function automatic logic mode_takes(input ssp_mode_t m);
        return m != MD_TX;
    endfunction

endpackage

// File: rtl/ssp_prescale.sv
module ssp_prescale #(
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - RW'(1);
        end
    end

    assign tick = en && (cnt_q == '0);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          fall,
    input  logic          rise,
    input  logic          finish,
    input  logic          din,
    output logic          dout,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic          dout_q;

    // outgoing side: bit 0 first, ones fill behind the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '1;
            dout_q <= 1'b1;
        end else if (load) begin
            dout_q <= load_val[0];
            tx_q   <= {1'b1, load_val[DW-1:1]};
        end else if (fall) begin
            dout_q <= tx_q[0];
            tx_q   <= {1'b1, tx_q[DW-1:1]};
        end else if (finish) begin
            dout_q <= 1'b1;
        end
    end

    // incoming side: first sampled bit ends up in position 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise) begin
            rx_q <= {din, rx_q[DW-1:1]};
        end
    end

    assign dout    = dout_q;
    assign rx_word = rx_q;
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
    import ssp_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_run,
    input  logic      cfg_loop,
    input  logic      rxen,
    input  logic      tbuf_full,
    input  logic      tick,
    output logic      busy,
    output logic      load,
    output logic      fall,
    output logic      rise,
    output logic      finish,
    output ssp_mode_t start_mode,
    output ssp_mode_t mode,
    output logic      sclk
);
    localparam int unsigned BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    ssp_state_t     state_q, state_d;
    ssp_mode_t      mode_q;
    logic [BCW-1:0] bit_q;
    logic           sclk_q;
    logic           go_tx, go_rx, go_loop, go_any;

    // start decision: half duplex outside loop-back
    always_comb begin
        go_loop = cfg_run && cfg_loop && rxen && tbuf_full;
        go_tx   = cfg_run && !cfg_loop && !rxen && tbuf_full;
        go_rx   = cfg_run && !cfg_loop && rxen;
        go_any  = go_loop || go_tx || go_rx;
        if (go_loop) begin
            start_mode = MD_LOOP;
        end else if (go_rx) begin
            start_mode = MD_RX;
        end else begin
            start_mode = MD_TX;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_any) state_d = ST_LOW;
            ST_LOW:  if (tick) state_d = ST_HIGH;
            ST_HIGH: if (tick) state_d = (bit_q == LAST_BIT) ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // edge strobes
    assign load   = (state_q == ST_IDLE) && go_any;
    assign rise   = (state_q == ST_LOW) && tick;
    assign fall   = (state_q == ST_HIGH) && tick && (bit_q != LAST_BIT);
    assign finish = (state_q == ST_HIGH) && tick && (bit_q == LAST_BIT);

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            bit_q  <= '0;
            mode_q <= MD_TX;
        end else begin
            if (load) begin
                sclk_q <= 1'b0;
                bit_q  <= '0;
                mode_q <= start_mode;
            end else if (fall) begin
                sclk_q <= 1'b0;
                bit_q  <= bit_q + BCW'(1);
            end else if (rise || finish) begin
                sclk_q <= 1'b1;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign mode = mode_q;
    assign sclk = sclk_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_run,
    input  logic          cfg_loop,
    input  logic          cfg_ovchk,
    input  logic          rxen_set,
    input  logic          rxen_clr,
    output logic          rxen_o,
    input  logic          ovf_clr,
    output logic          ovf_o,
    input  logic [RW-1:0] reload,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    output logic          sclk_o,
    output logic          data_o,
    output logic          data_oe,
    input  logic          data_i,
    output logic          req_tbuf,
    output logic          req_txdone,
    output logic          req_rxdone,
    output logic          req_err
);
    ssp_mode_t     mode_q, mode_start;
    logic          busy, load, fall, rise, finish, tick;
    logic          tbuf_full_q, unread_q, ovf_q, rxen_q;
    logic [DW-1:0] tbuf_q, rbuf_q, rx_word, load_val;
    logic          dout, din;
    logic          rx_only_busy, tx_take, rx_end, tx_end, overrun;
    logic          p_tbuf_q, p_txdone_q, p_rxdone_q, p_err_q;

    ssp_prescale #(.RW(RW)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(busy), .reload(reload), .tick(tick)
    );

    ssp_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_loop(cfg_loop),
        .rxen(rxen_q), .tbuf_full(tbuf_full_q), .tick(tick), .busy(busy),
        .load(load), .fall(fall), .rise(rise), .finish(finish),
        .start_mode(mode_start), .mode(mode_q), .sclk(sclk_o)
    );

    ssp_shift #(.DW(DW)) u_shf (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .fall(fall), .rise(rise), .finish(finish), .din(din),
        .dout(dout), .rx_word(rx_word)
    );

    assign rx_only_busy = busy && (mode_q == MD_RX);
    assign tx_take      = load && mode_sends(mode_start);
    assign rx_end       = finish && mode_takes(mode_q);
    assign tx_end       = finish && mode_sends(mode_q);
    assign overrun      = rx_end && unread_q && cfg_ovchk;
    assign load_val     = mode_sends(mode_start) ? tbuf_q : '1;
    assign din          = (mode_q == MD_LOOP) ? dout : data_i;

    // transmit holding buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbuf_full_q <= 1'b0;
            tbuf_q      <= '0;
        end else if (tx_wr && !rx_only_busy) begin
            tbuf_full_q <= 1'b1;
            tbuf_q      <= tx_data;
        end else if (tx_take) begin
            tbuf_full_q <= 1'b0;
        end
    end

    // receive buffer, unread marker, overrun flag, receiver enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q   <= '0;
            unread_q <= 1'b0;
            ovf_q    <= 1'b0;
            rxen_q   <= 1'b0;
        end else begin
            if (rx_end) begin
                rbuf_q <= rx_word;
            end
            if (rx_end) begin
                unread_q <= 1'b1;
            end else if (rx_rd) begin
                unread_q <= 1'b0;
            end
            if (overrun) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
            if (rx_end) begin
                rxen_q <= 1'b0;
            end else if (rxen_set) begin
                rxen_q <= 1'b1;
            end else if (rxen_clr) begin
                rxen_q <= 1'b0;
            end
        end
    end

    // request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_tbuf_q   <= 1'b0;
            p_txdone_q <= 1'b0;
            p_rxdone_q <= 1'b0;
            p_err_q    <= 1'b0;
        end else begin
            p_tbuf_q   <= tx_take;
            p_txdone_q <= tx_end;
            p_rxdone_q <= rx_end;
            p_err_q    <= overrun;
        end
    end

    assign rxen_o     = rxen_q;
    assign ovf_o      = ovf_q;
    assign rx_data    = rbuf_q;
    assign data_o     = dout;
    assign data_oe    = !rx_only_busy;
    assign req_tbuf   = p_tbuf_q;
    assign req_txdone = p_txdone_q;
    assign req_rxdone = p_rxdone_q;
    assign req_err    = p_err_q;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic data_o,
    input logic rxen_o,
    input logic ovf_o,
    input logic req_tbuf,
    input logic req_txdone,
    input logic req_rxdone,
    input logic req_err
);
    AST_TXDONE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_txdone |-> (sclk_o && data_o)); // R4
    AST_TBUF_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_tbuf |-> !sclk_o); // R2
    AST_TX_REQ_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_tbuf && req_txdone)); // R4
    AST_RXEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        req_rxdone |-> !rxen_o); // R7
    AST_RXDONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_rxdone |=> !req_rxdone); // R7
    AST_ERR_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_rxdone && ovf_o)); // R10
endmodule

bind sync_shift_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .data_o(data_o),
    .rxen_o(rxen_o), .ovf_o(ovf_o), .req_tbuf(req_tbuf),
    .req_txdone(req_txdone), .req_rxdone(req_rxdone), .req_err(req_err)
);

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_run = 0, cfg_loop = 0, cfg_ovchk = 0;
    logic rxen_set = 0, rxen_clr = 0, ovf_clr = 0, tx_wr = 0, rx_rd = 0;
    logic [7:0] reload = 8'd2;
    logic [7:0] tx_data = 8'h00;
    logic data_i = 1'b1;
    logic rxen_o, ovf_o, sclk_o, data_o, data_oe;
    logic req_tbuf, req_txdone, req_rxdone, req_err;
    logic [7:0] rx_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_tbuf = 0, n_txd = 0, n_rxd = 0, n_err = 0, n_fall = 0;
    int di_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_sclk = 1'b1;
    logic [7:0] cap = 8'h00;
    int ncap = 0;
    logic [7:0] capq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_shift_port #(.DW(8), .RW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_loop(cfg_loop),
        .cfg_ovchk(cfg_ovchk), .rxen_set(rxen_set), .rxen_clr(rxen_clr),
        .rxen_o(rxen_o), .ovf_clr(ovf_clr), .ovf_o(ovf_o), .reload(reload),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
        .req_tbuf(req_tbuf), .req_txdone(req_txdone), .req_rxdone(req_rxdone),
        .req_err(req_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic m_busy, m_tx, m_rx, m_lp, m_sclk, m_dout, m_tfull, m_unread, m_ovf, m_rxen;
    logic [7:0] m_tbuf, m_txb, m_rxb, m_rbuf;
    logic m_ptb, m_ptd, m_prd, m_per;
    int m_half, m_cnt;

    always @(posedge clk) begin
        logic o_rxonly, o_tfull, o_rxen, fin_rx;
        if (!rst_n) begin
            m_busy = 0; m_tx = 0; m_rx = 0; m_lp = 0; m_sclk = 1; m_dout = 1;
            m_tfull = 0; m_unread = 0; m_ovf = 0; m_rxen = 0;
            m_tbuf = 0; m_txb = 0; m_rxb = 0; m_rbuf = 0;
            m_ptb = 0; m_ptd = 0; m_prd = 0; m_per = 0; m_half = 0; m_cnt = 0;
        end else begin
            o_rxonly = m_busy && m_rx && !m_tx;
            o_tfull = m_tfull;
            o_rxen = m_rxen;
            fin_rx = 0;
            m_ptb = 0; m_ptd = 0; m_prd = 0; m_per = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_half % 2 == 0) begin
                        m_sclk = 1;
                        m_rxb[m_half/2] = m_lp ? m_dout : data_i;
                        m_half++;
                        m_cnt = int'(reload) + 1;
                    end else if (m_half == 15) begin
                        m_busy = 0; m_sclk = 1; m_dout = 1;
                        m_ptd = m_tx;
                        if (m_rx) begin
                            m_prd = 1; fin_rx = 1;
                            if (m_unread && cfg_ovchk) begin m_ovf = 1; m_per = 1; end
                            m_rbuf = m_rxb;
                        end
                    end else begin
                        m_sclk = 0;
                        m_half++;
                        m_dout = m_tx ? m_txb[m_half/2] : 1'b1;
                        m_cnt = int'(reload) + 1;
                    end
                end
            end else if (cfg_run) begin
                if (o_tfull && ((cfg_loop && o_rxen) || (!cfg_loop && !o_rxen))) begin
                    m_tx = 1; m_rx = cfg_loop; m_lp = cfg_loop;
                    m_txb = m_tbuf; m_tfull = 0; m_ptb = 1;
                    m_busy = 1; m_half = 0; m_cnt = int'(reload) + 1; m_sclk = 0; m_dout = m_txb[0];
                end else if (!cfg_loop && o_rxen) begin
                    m_tx = 0; m_rx = 1; m_lp = 0;
                    m_busy = 1; m_half = 0; m_cnt = int'(reload) + 1; m_sclk = 0; m_dout = 1;
                end
            end
            if (tx_wr && !o_rxonly) begin m_tfull = 1; m_tbuf = tx_data; end
            if (fin_rx) m_rxen = 0;
            else if (rxen_set) m_rxen = 1;
            else if (rxen_clr) m_rxen = 0;
            if (fin_rx) m_unread = 1;
            else if (rx_rd) m_unread = 0;
            if (!m_per && ovf_clr) m_ovf = 0;
        end
    end

    // ---------------- per-clock comparison and event monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            check(sclk_o === m_sclk, "R3 sclk", sclk_o, m_sclk);
            check(data_o === m_dout, "R3 data_o", data_o, m_dout);
            check(data_oe === !(m_busy && m_rx && !m_tx), "R6 data_oe", data_oe, !(m_busy && m_rx && !m_tx));
            check(req_tbuf === m_ptb, "R2 req_tbuf", req_tbuf, m_ptb);
            check(req_txdone === m_ptd, "R4 req_txdone", req_txdone, m_ptd);
            check(req_rxdone === m_prd, "R7 req_rxdone", req_rxdone, m_prd);
            check(rxen_o === m_rxen, "R7 rxen", rxen_o, m_rxen);
            check(req_err === m_per, "R10 req_err", req_err, m_per);
            check(ovf_o === m_ovf, "R10 ovf", ovf_o, m_ovf);
            check(rx_data === m_rbuf, "R6 rx_data", rx_data, m_rbuf);
            if (req_tbuf) n_tbuf++;
            if (req_txdone) n_txd++;
            if (req_rxdone) n_rxd++;
            if (req_err) n_err++;
            if (prev_sclk && !sclk_o) n_fall++;
            if (!prev_sclk && sclk_o) begin
                cap = {data_o, cap[7:1]};
                ncap++;
                if (ncap % 8 == 0) capq.push_back(cap);
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            data_i = (di_mode == 0) ? lfsr[0] : (di_mode == 2);
        end
        #1;
    endtask

    task automatic write_tx(input logic [7:0] v);
        tx_data = v; tx_wr = 1; wait_clk(1); tx_wr = 0;
    endtask

    task automatic pulse_rxen();
        rxen_set = 1; wait_clk(1); rxen_set = 0;
    endtask

    task automatic wait_rx();
        int s = n_rxd;
        for (int i = 0; i < 600 && n_rxd == s; i++) wait_clk(1);
        wait_clk(2);
    endtask

    task automatic wait_tx(input int k);
        int s = n_txd;
        for (int i = 0; i < 1200 && n_txd < s + k; i++) wait_clk(1);
        wait_clk(2);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int s_fall, s_txd, lat, s_err;
        wait_clk(3);
        rst_n = 1;
        #1;
        // R1 reset values
        check(sclk_o && data_o && data_oe, "R1 lines", {sclk_o, data_o, data_oe}, 3'b111);
        check(!req_tbuf && !req_txdone && !req_rxdone && !req_err, "R1 requests",
              {req_tbuf, req_txdone, req_rxdone, req_err}, 0);
        check(!rxen_o && !ovf_o, "R1 flags", {rxen_o, ovf_o}, 0);

        // R2, R3, R4: double-buffered transmit
        cfg_run = 1;
        capq.delete(); ncap = 0;
        write_tx(8'h3C);
        lat = 1;
        while (sclk_o && lat < 10) begin wait_clk(1); lat++; end
        check(lat <= 4, "R2 start latency", lat, 4);
        check(n_tbuf == 1, "R2 tbuf pulse", n_tbuf, 1);
        write_tx(8'hC5);
        wait_tx(2);
        check(capq.size() == 2, "R4 byte count", capq.size(), 2);
        if (capq.size() == 2) begin
            check(capq[0] == 8'h3C, "R3 first byte", capq[0], 8'h3C);
            check(capq[1] == 8'hC5, "R4 buffered byte", capq[1], 8'hC5);
        end
        check(n_tbuf == 2, "R4 second tbuf pulse", n_tbuf, 2);

        // R5: run cleared holds the byte
        cfg_run = 0;
        s_fall = n_fall;
        write_tx(8'h96);
        wait_clk(40);
        check(n_fall == s_fall, "R5 no start without run", n_fall, s_fall);
        capq.delete(); ncap = 0;
        cfg_run = 1;
        wait_tx(1);
        check(capq.size() == 1 && capq[0] == 8'h96, "R5 held byte sent",
              capq.size() ? capq[0] : 0, 8'h96);

        // R3: shortest half period
        reload = 8'd0;
        capq.delete(); ncap = 0;
        write_tx(8'h5A);
        wait_tx(1);
        check(capq.size() == 1 && capq[0] == 8'h5A, "R3 reload zero",
              capq.size() ? capq[0] : 0, 8'h5A);
        reload = 8'd2;

        // R6, R7: receive of constant patterns and random data
        di_mode = 1;
        pulse_rxen();
        wait_rx();
        check(rx_data == 8'h00, "R6 zeros", rx_data, 8'h00);
        check(!rxen_o, "R7 enable self-clear", rxen_o, 0);
        rx_rd = 1; wait_clk(1); rx_rd = 0;
        di_mode = 2;
        pulse_rxen();
        wait_rx();
        check(rx_data == 8'hFF, "R6 ones", rx_data, 8'hFF);
        rx_rd = 1; wait_clk(1); rx_rd = 0;
        di_mode = 0;
        pulse_rxen();
        wait_rx();
        rx_rd = 1; wait_clk(1); rx_rd = 0;

        // R8: early clear completes the byte
        s_fall = n_rxd;
        pulse_rxen();
        wait_clk(10);
        rxen_clr = 1; wait_clk(1); rxen_clr = 0;
        wait_rx();
        check(n_rxd == s_fall + 1, "R8 byte finished", n_rxd, s_fall + 1);
        rx_rd = 1; wait_clk(1); rx_rd = 0;

        // R9: transmit write during receive is dropped
        s_txd = n_txd;
        pulse_rxen();
        wait_clk(6);
        write_tx(8'h77);
        wait_rx();
        s_fall = n_fall;
        wait_clk(150);
        check(n_fall == s_fall, "R9 no transfer after receive", n_fall, s_fall);
        check(n_txd == s_txd, "R9 no transmit done", n_txd, s_txd);
        rx_rd = 1; wait_clk(1); rx_rd = 0;

        // R10: overrun with checking on
        cfg_ovchk = 1;
        s_err = n_err;
        pulse_rxen(); wait_rx();
        pulse_rxen(); wait_rx();
        check(ovf_o == 1, "R10 overrun flag", ovf_o, 1);
        check(n_err == s_err + 1, "R10 error pulse", n_err, s_err + 1);
        ovf_clr = 1; wait_clk(1); ovf_clr = 0;
        check(ovf_o == 0, "R10 flag clear", ovf_o, 0);
        rx_rd = 1; wait_clk(1); rx_rd = 0;
        pulse_rxen(); wait_rx();
        check(n_err == s_err + 1 && !ovf_o, "R10 read avoids overrun", n_err, s_err + 1);
        // overrun with checking off
        cfg_ovchk = 0;
        pulse_rxen(); wait_rx();
        check(n_err == s_err + 1 && !ovf_o, "R10 check disabled", n_err, s_err + 1);
        rx_rd = 1; wait_clk(1); rx_rd = 0;

        // R11: loop-back ignores the data input
        cfg_loop = 1;
        di_mode = 1;
        s_txd = n_txd; s_fall = n_rxd;
        pulse_rxen();
        write_tx(8'hA5);
        wait_tx(1);
        check(rx_data == 8'hA5, "R11 looped byte", rx_data, 8'hA5);
        check(n_rxd == s_fall + 1 && n_txd == s_txd + 1, "R11 both done pulses",
              n_rxd - s_fall, 1);
        check(!rxen_o, "R11 enable cleared", rxen_o, 0);
        cfg_loop = 0;
        di_mode = 0;
        wait_clk(5);
        report();
    end
endmodule